// File: doc/BRIEF.md
# Saturating PI Loop Controller

This block is the loop filter of a digital phase-locked loop. A phase detector upstream delivers one signed error sample at a time with a strobe. For each strobe the block adds the error to a running integrator and weights the sum and the raw error with programmable fixed-point gains. It then scales the result down, offsets it by a bias and clamps it into a programmable window. The clamped word is registered and drives an actuator such as the DAC that steers an oscillator.

The gains carry 16 fractional bits, and all products are formed at 64 bits so that a large integrator cannot wrap the arithmetic. An anti-windup option stops the integrator from growing while the output is pinned at a limit. A one-cycle init pulse restarts the loop: it clears the integrator and loads the output with the bias.

Top module: `pi_loop_ctrl`

## Requirements
- R1: While `rst_n` is low, `y_out` is 0 and `out_valid` is 0.
- R2: An `init` pulse clears the integrator and sets `y_out` to `bias` at the next clock edge, with `out_valid` low. `init` takes priority over a strobe that arrives in the same cycle, and that strobe is dropped.
- R3: For a strobe with error e and stored integrator I, the candidate integrator is c = I + e, wrapped to 32-bit two's complement. The unclamped result is s = floor((c·ki + e·kp) / 2^16) + bias, where the division is an arithmetic right shift by 16 and `bias` is unsigned.
- R4: `y_out` equals s when `y_min` ≤ s ≤ `y_max`, `y_max` when s > `y_max`, and `y_min` when s < `y_min`. Both limits are unsigned and inclusive, and `y_min` ≤ `y_max` is assumed.
- R5: `y_out` changes and `out_valid` pulses high for exactly one cycle on the clock edge after each accepted strobe, so back-to-back strobes give back-to-back results. Without a strobe or init, `y_out` and the integrator hold.
- R6: With `anti_windup` = 1, a strobe whose s lies outside [`y_min`, `y_max`] leaves the integrator unchanged. A strobe whose s is inside the window, limits included, stores c.
- R7: With `anti_windup` = 0, every accepted strobe stores c in the integrator, even when the output is clamped.
- R8: Both products and their sum are exact at 64 bits. A result is correct when c·ki or the sum of the products exceeds the 32-bit range but the final s fits the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Restart pulse: clear integrator, load bias |
| in_valid | input | 1 | Error sample strobe |
| err_in | input | DATA_W (32) | Signed phase error sample |
| kp | input | COEF_W (32) | Signed proportional gain, 16 fractional bits |
| ki | input | COEF_W (32) | Signed integral gain, 16 fractional bits |
| bias | input | OUT_W (16) | Unsigned output offset |
| y_min | input | OUT_W (16) | Lower output limit, inclusive |
| y_max | input | OUT_W (16) | Upper output limit, inclusive |
| anti_windup | input | 1 | 1: freeze the integrator while saturated |
| y_out | output | OUT_W (16) | Clamped actuator word |
| out_valid | output | 1 | One-cycle pulse with each new result |

## Verification
Assertions check on every cycle that:
- a result never leaves the window that was programmed when it was computed;
- `out_valid` follows exactly the accepted strobes one cycle later;
- init clears the integrator and loads the bias;
- the integrator stays still when saturated under anti-windup, and takes the candidate otherwise;
- nothing moves when no strobe or init arrives.

Only the bench scenarios show the arithmetic itself. These cover the floor behaviour of the shift on negative sums, exactness when products pass the 32-bit range, and results that land exactly on a limit. They also show the later effect of a frozen or committed integrator on following outputs.

// File: rtl/pi_loop_pkg.sv
package pi_loop_pkg;
   localparam int PI_DATA_W_DEF = 32;
   localparam int PI_COEF_W_DEF = 32;
   localparam int PI_PROD_W_DEF = 64;
   localparam int PI_FRAC_DEF   = 16;
   localparam int PI_OUT_W_DEF  = 16;

   typedef enum logic [1:0] {
      SAT_NONE = 2'd0,
      SAT_LOW  = 2'd1,
      SAT_HIGH = 2'd2
   } sat_kind_e;
endpackage

// File: rtl/pi_mac.sv
module pi_mac #(
   parameter int DATA_W    = 32,
   parameter int COEF_W    = 32,
   parameter int PROD_W    = 64,
   parameter int FRAC_BITS = 16,
   parameter int OUT_W     = 16
) (
   input  logic signed [DATA_W-1:0] integ,
   input  logic signed [DATA_W-1:0] err,
   input  logic signed [COEF_W-1:0] kp,
   input  logic signed [COEF_W-1:0] ki,
   input  logic        [OUT_W-1:0]  bias,
   output logic signed [DATA_W-1:0] cand,
   output logic signed [PROD_W-1:0] sum
);
   localparam int BIAS_PAD = PROD_W - OUT_W;

   generate
      if (PROD_W < DATA_W + COEF_W) begin : g_chk_prod
         $error("pi_mac: PROD_W too narrow for exact products");
      end
      if (FRAC_BITS >= PROD_W) begin : g_chk_frac
         $error("pi_mac: FRAC_BITS must be below PROD_W");
      end
   endgenerate

   logic signed [PROD_W-1:0] cand_x, err_x, kp_x, ki_x;
   logic signed [PROD_W-1:0] prod_i, prod_p, acc, scaled;

   assign cand   = integ + err;
   assign cand_x = PROD_W'(cand);
   assign err_x  = PROD_W'(err);
   assign kp_x   = PROD_W'(kp);
   assign ki_x   = PROD_W'(ki);
   assign prod_i = cand_x * ki_x;
   assign prod_p = err_x * kp_x;
   assign acc    = prod_i + prod_p;
   assign scaled = acc >>> FRAC_BITS;
   assign sum    = scaled + $signed({{BIAS_PAD{1'b0}}, bias});
endmodule

// File: rtl/pi_clamp.sv
module pi_clamp
   import pi_loop_pkg::*;
#(
   parameter int PROD_W = 64,
   parameter int OUT_W  = 16
) (
   input  logic signed [PROD_W-1:0] sum,
   input  logic        [OUT_W-1:0]  lo,
   input  logic        [OUT_W-1:0]  hi,
   output logic        [OUT_W-1:0]  y,
   output sat_kind_e                kind
);
   localparam int PAD = PROD_W - OUT_W;

   generate
      if (OUT_W >= PROD_W) begin : g_chk_w
         $error("pi_clamp: OUT_W must be narrower than PROD_W");
      end
   endgenerate

   logic signed [PROD_W-1:0] lo_x, hi_x;
   assign lo_x = $signed({{PAD{1'b0}}, lo});
   assign hi_x = $signed({{PAD{1'b0}}, hi});

   always_comb begin
      if (sum > hi_x) begin
         kind = SAT_HIGH;
         y    = hi;
      end else if (sum < lo_x) begin
         kind = SAT_LOW;
         y    = lo;
      end else begin
         kind = SAT_NONE;
         y    = sum[OUT_W-1:0];
      end
   end
endmodule

// File: rtl/pi_loop_ctrl.sv
module pi_loop_ctrl
   import pi_loop_pkg::*;
#(
   parameter int DATA_W    = PI_DATA_W_DEF,
   parameter int COEF_W    = PI_COEF_W_DEF,
   parameter int PROD_W    = PI_PROD_W_DEF,
   parameter int FRAC_BITS = PI_FRAC_DEF,
   parameter int OUT_W     = PI_OUT_W_DEF
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     init,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] err_in,
   input  logic signed [COEF_W-1:0] kp,
   input  logic signed [COEF_W-1:0] ki,
   input  logic        [OUT_W-1:0]  bias,
   input  logic        [OUT_W-1:0]  y_min,
   input  logic        [OUT_W-1:0]  y_max,
   input  logic                     anti_windup,
   output logic        [OUT_W-1:0]  y_out,
   output logic                     out_valid
);
   generate
      if (OUT_W < 2 || DATA_W < 2 || COEF_W < 2) begin : g_chk_sizes
         $error("pi_loop_ctrl: widths too small");
      end
   endgenerate

   logic signed [DATA_W-1:0] integ_q;
   logic signed [DATA_W-1:0] cand;
   logic signed [PROD_W-1:0] sum;
   logic        [OUT_W-1:0]  y_clamped;
   sat_kind_e                sat_kind;
   logic                     accept, saturated, commit;

   pi_mac #(
      .DATA_W(DATA_W), .COEF_W(COEF_W), .PROD_W(PROD_W),
      .FRAC_BITS(FRAC_BITS), .OUT_W(OUT_W)
   ) u_mac (
      .integ(integ_q), .err(err_in), .kp(kp), .ki(ki), .bias(bias),
      .cand(cand), .sum(sum)
   );

   pi_clamp #(.PROD_W(PROD_W), .OUT_W(OUT_W)) u_clamp (
      .sum(sum), .lo(y_min), .hi(y_max), .y(y_clamped), .kind(sat_kind)
   );

   assign accept    = in_valid && !init;
   assign saturated = (sat_kind != SAT_NONE);
   assign commit    = !(anti_windup && saturated);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         integ_q   <= '0;
         y_out     <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= accept;
         if (init) begin
            integ_q <= '0;
            y_out   <= bias;
         end else if (in_valid) begin
            y_out <= y_clamped;
            if (commit) integ_q <= cand;
         end
      end
   end

   // Assertions

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |-> (y_out == '0 && !out_valid));

   assert_init_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      init |=> (integ_q == '0 && y_out == $past(bias) && !out_valid));

   assert_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(y_min <= y_max)) |->
         (y_out >= $past(y_min) && y_out <= $past(y_max)));

   assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);

   assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> !out_valid);

   assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && !init) |=> ($stable(y_out) && $stable(integ_q)));

   assert_freeze_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && anti_windup && sat_kind != SAT_NONE) |=> $stable(integ_q));

   assert_commit_inside_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && sat_kind == SAT_NONE) |=> (integ_q == $past(cand)));

   assert_commit_no_aw_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !anti_windup) |=> (integ_q == $past(cand)));
endmodule

// File: tb/pi_loop_ctrl_bench.sv
module pi_loop_ctrl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int OUT_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic init = 1'b0;
   logic in_valid = 1'b0;
   logic signed [31:0] err_in = '0;
   logic signed [31:0] kp = 32'sd2400;
   logic signed [31:0] ki = 32'sd32;
   logic [OUT_W-1:0] bias = 16'd30000;
   logic [OUT_W-1:0] y_min = 16'd5;
   logic [OUT_W-1:0] y_max = 16'd65531;
   logic anti_windup = 1'b1;
   logic [OUT_W-1:0] y_out;
   logic out_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int integ_m = 0;

   logic [OUT_W-1:0] exp_q[$];
   string            tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   pi_loop_ctrl u_pi_loop_ctrl (
      .clk(clk), .rst_n(rst_n), .init(init), .in_valid(in_valid),
      .err_in(err_in), .kp(kp), .ki(ki), .bias(bias),
      .y_min(y_min), .y_max(y_max), .anti_windup(anti_windup),
      .y_out(y_out), .out_valid(out_valid)
   );

   task automatic check(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // driver: applies one strobe and pushes the expected result
   task automatic send(input int e, input string req);
      int cand;
      longint p, s;
      logic [OUT_W-1:0] y;
      bit sat;
      @(negedge clk);
      err_in   = e;
      in_valid = 1'b1;
      cand = integ_m + e;
      p = longint'(cand) * longint'(ki) + longint'(e) * longint'(kp);
      s = (p >>> 16) + longint'(bias);
      sat = 1'b0;
      if (s > longint'(y_max)) begin y = y_max; sat = 1'b1; end
      else if (s < longint'(y_min)) begin y = y_min; sat = 1'b1; end
      else y = s[OUT_W-1:0];
      if (!(anti_windup && sat)) integ_m = cand;
      exp_q.push_back(y);
      tag_q.push_back(req);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic do_init(input bit with_strobe);
      @(negedge clk);
      init     = 1'b1;
      in_valid = with_strobe;
      err_in   = 32'sd12345;
      @(negedge clk);
      init     = 1'b0;
      in_valid = 1'b0;
      integ_m  = 0;
      check("R2 init loads bias", y_out, bias);
      check("R2 no valid on init", out_valid, 0);
   endtask

   // monitor: compares each result against the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            check("R5 unexpected out_valid", 1, 0);
         end else begin
            string t;
            logic [OUT_W-1:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, y_out, e);
         end
      end
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [OUT_W-1:0] held;
      repeat (3) @(negedge clk);
      check("R1 reset y_out", y_out, 0);
      check("R1 reset out_valid", out_valid, 0);
      rst_n = 1'b1;

      do_init(1'b0);

      // R3 R5: back-to-back mixed-sign samples
      send(0, "R3 zero error");
      send(1000, "R3 positive error");
      send(-1000, "R3 negative error");
      send(5000, "R5 back to back");
      send(-37, "R3 floor shift negative");
      idle(2);

      // R5: hold while idle
      held = y_out;
      repeat (5) @(negedge clk);
      check("R5 hold y_out", y_out, held);
      check("R5 no valid idle", out_valid, 0);

      // R4 R6: saturate high and low with anti-windup, then recover
      send(2000000, "R4 clamp high");
      send(0, "R6 frozen after high");
      send(-3000000, "R4 clamp low");
      send(0, "R6 frozen after low");
      idle(2);

      // R7: anti-windup off, integrator keeps growing
      do_init(1'b0);
      anti_windup = 1'b0;
      send(2000000, "R7 clamp no aw");
      send(2000000, "R7 clamp no aw again");
      send(-100000, "R7 wound integrator");
      send(-9000000, "R7 unwinding");
      idle(2);
      anti_windup = 1'b1;

      // R8: products beyond 32 bits, final result in range
      do_init(1'b0);
      ki = 32'sd65536; kp = -32'sd65536; bias = 16'd5000;
      idle(1);
      do_init(1'b0);
      send(40000, "R8 large candidate");
      send(-10000, "R8 sum past 32 bits");
      idle(2);

      // R4: inclusive limits, output follows error directly
      ki = 32'sd0; kp = 32'sd65536; bias = 16'd0;
      do_init(1'b0);
      send(65531, "R4 at upper limit");
      send(65532, "R4 above upper limit");
      send(5, "R4 at lower limit");
      send(4, "R4 below lower limit");
      send(-1, "R4 negative below limit");
      idle(2);

      // R6: result exactly at the limit commits the integrator
      ki = 32'sd65536; kp = 32'sd0;
      do_init(1'b0);
      send(65531, "R6 exact limit commits");
      send(-65000, "R6 committed value used");
      idle(2);

      // R2: init wins over a simultaneous strobe
      bias = 16'd30000; kp = 32'sd2400; ki = 32'sd32;
      do_init(1'b1);
      repeat (2) @(negedge clk);
      check("R2 strobe with init dropped", y_out, bias);
      send(0, "R2 integrator cleared");
      idle(3);

      check("R5 scoreboard drained", exp_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule